// File: doc/BRIEF.md
# Operand-Inverting 32-bit ALU

This block is a purely combinational arithmetic and logic unit for a single-cycle datapath. It takes two 32-bit operands and a 4-bit operation code. It returns a 32-bit result and a flag that is high when that result is all zeros. The flag lets a branch unit test two registers for equality: it requests a subtraction and looks at the flag.

The code is split into two parts. The two upper bits decide whether each operand is complemented before it enters a shared stage. That stage holds a bitwise AND, a bitwise OR, a ripple-carry adder and a signed less-than. The two lower bits pick which of the four stage outputs reaches the result. Subtraction, NOR and set-on-less-than are therefore not separate units:

- Subtraction is addition with the second operand complemented and a carry-in of 1.
- NOR is the AND of both complemented operands.
- Set-on-less-than reads the sign of the difference, corrected for overflow.

Codes outside the supported set give a zero result. The block has no carry-out and no overflow output.

Top module: `inv_alu`

## Requirements
- R1: Code 4'b0000 outputs the bitwise AND of the two operands.
- R2: Code 4'b0001 outputs the bitwise OR of the two operands.
- R3: Code 4'b0010 outputs the sum of the operands modulo 2^32, with no carry or overflow indication.
- R4: Code 4'b0110 outputs operand A minus operand B modulo 2^32. Bit 2 of the code complements B, and the adder carry-in is then 1.
- R5: Code 4'b0111 outputs 1 in bit 0 when A is less than B as two's-complement numbers, and 0 otherwise. The comparison is correct even when A minus B overflows. Bits 31..1 are zero.
- R6: Code 4'b1100 outputs the bitwise NOR of the operands, formed by complementing both operands (bits 3 and 2) and selecting AND (bits 1..0 = 00).
- R7: The zero flag is high exactly when the 32-bit result is all zeros, for every code.
- R8: Every code other than 0000, 0001, 0010, 0110, 0111 and 1100 gives a result of zero, so the zero flag is high.
- R9: With code 4'b0110, the zero flag is high exactly when the two operands are equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 4 | Bit 3 complements A, bit 2 complements B, bits 1..0 select AND/OR/sum/less-than |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| result | output | 32 | Selected function output |
| zero | output | 1 | High when result is all zeros |

## Verification
The assertions are immediate checks evaluated whenever the combinational inputs change. They assume op_code, opnd_a and opnd_b are known values with no X or Z bits. The bench drives every input from reset onward, so none of them is ever left undriven. Inputs change only just after a rising edge, and outputs are sampled on the falling edge, so each check sees settled values. The stimulus covers the values where the less-than overflow correction matters: the most positive and most negative numbers, and equal operands.

// File: rtl/inv_alu_pkg.sv
package inv_alu_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } sel_e;

  localparam logic [OPC_W-1:0] OPC_AND  = 4'b0000;
  localparam logic [OPC_W-1:0] OPC_OR   = 4'b0001;
  localparam logic [OPC_W-1:0] OPC_ADD  = 4'b0010;
  localparam logic [OPC_W-1:0] OPC_SUB  = 4'b0110;
  localparam logic [OPC_W-1:0] OPC_SLT  = 4'b0111;
  localparam logic [OPC_W-1:0] OPC_NOR  = 4'b1100;

  function automatic logic opc_supported(input logic [OPC_W-1:0] c);
    logic ok;
    case (c)
      OPC_AND, OPC_OR, OPC_ADD, OPC_SUB, OPC_SLT, OPC_NOR: ok = 1'b1;
      default:                                              ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] raw_a,
  input  logic [W-1:0] raw_b,
  input  logic         flip_a,
  input  logic         flip_b,
  output logic [W-1:0] eff_a,
  output logic [W-1:0] eff_b,
  output logic         carry_in
);

  // Complementing B turns the adder into a subtractor; the +1 comes in here.
  always_comb begin
    eff_a    = flip_a ? ~raw_a : raw_a;
    eff_b    = flip_b ? ~raw_b : raw_b;
    carry_in = flip_b;
  end

endmodule

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] add_a,
  input  logic [W-1:0] add_b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         signed_less
);

  localparam int MSB = W - 1;

  logic [W:0] carry;
  logic       ovf;

  assign carry[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]     = add_a[i] ^ add_b[i] ^ carry[i];
    assign carry[i+1] = (add_a[i] & add_b[i]) | (carry[i] & (add_a[i] ^ add_b[i]));
  end

  // Signed overflow when carry into and out of the sign bit differ.
  assign ovf         = carry[W] ^ carry[MSB];
  assign signed_less = sum[MSB] ^ ovf;

endmodule

// File: rtl/alu_result_sel.sv
module alu_result_sel
  import inv_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] eff_a,
  input  logic [W-1:0] eff_b,
  input  logic [W-1:0] sum,
  input  logic         less,
  input  sel_e         sel,
  input  logic         legal,
  output logic [W-1:0] res
);

  logic [W-1:0] pick;

  always_comb begin
    case (sel)
      SEL_AND:  pick = eff_a & eff_b;
      SEL_OR:   pick = eff_a | eff_b;
      SEL_SUM:  pick = sum;
      default:  pick = {{(W-1){1'b0}}, less};
    endcase
    res = legal ? pick : '0;
  end

endmodule

// File: rtl/inv_alu.sv
module inv_alu
  import inv_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [OPC_W-1:0] op_code,
  input  logic [W-1:0]     opnd_a,
  input  logic [W-1:0]     opnd_b,
  output logic [W-1:0]     result,
  output logic             zero
);

  logic [W-1:0] a_eff;
  logic [W-1:0] b_eff;
  logic         cin;
  logic [W-1:0] sum;
  logic         less;
  logic         legal;
  sel_e         sel;

  assign legal = opc_supported(op_code);
  assign sel   = sel_e'(op_code[1:0]);

  alu_operand_prep #(.W(W)) u_prep (
    .raw_a    (opnd_a),
    .raw_b    (opnd_b),
    .flip_a   (op_code[3]),
    .flip_b   (op_code[2]),
    .eff_a    (a_eff),
    .eff_b    (b_eff),
    .carry_in (cin)
  );

  alu_ripple_adder #(.W(W)) u_add (
    .add_a       (a_eff),
    .add_b       (b_eff),
    .cin         (cin),
    .sum         (sum),
    .signed_less (less)
  );

  alu_result_sel #(.W(W)) u_sel (
    .eff_a (a_eff),
    .eff_b (b_eff),
    .sum   (sum),
    .less  (less),
    .sel   (sel),
    .legal (legal),
    .res   (result)
  );

  assign zero = ~|result;

  always_comb begin
    if (op_code == OPC_AND) begin
      // R1
      and_func_chk: assert (result == (opnd_a & opnd_b)) else $error("AND mismatch");
    end
    if (op_code == OPC_OR) begin
      // R2
      or_func_chk: assert (result == (opnd_a | opnd_b)) else $error("OR mismatch");
    end
    if (op_code == OPC_ADD) begin
      // R3
      add_func_chk: assert (result - opnd_b == opnd_a) else $error("sum mismatch");
    end
    if (op_code == OPC_SUB) begin
      // R4
      sub_func_chk: assert (result + opnd_b == opnd_a) else $error("difference mismatch");
      // R9
      eq_zero_chk: assert ((opnd_a == opnd_b) == zero) else $error("equality flag mismatch");
    end
    if (op_code == OPC_SLT) begin
      // R5
      slt_func_chk: assert (result == {{(W-1){1'b0}}, ($signed(opnd_a) < $signed(opnd_b))})
        else $error("less-than mismatch");
    end
    if (op_code == OPC_NOR) begin
      // R6
      nor_func_chk: assert (result == ~(opnd_a | opnd_b)) else $error("NOR mismatch");
    end
    if (!opc_supported(op_code)) begin
      // R8
      unknown_op_chk: assert (result == '0 && zero) else $error("unsupported code leaked");
    end
  end

endmodule

// File: tb/test_inv_alu.sv
module test_inv_alu;

  logic        clk;
  logic        rst_n;
  logic [3:0]  op_code;
  logic [31:0] opnd_a;
  logic [31:0] opnd_b;
  logic [31:0] result;
  logic        zero;

  int total;
  int bad;
  bit finished;

  inv_alu i_inv_alu (
    .op_code (op_code),
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .result  (result),
    .zero    (zero)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] model(input logic [3:0] c, input logic [31:0] a,
                                        input logic [31:0] b);
    case (c)
      4'b0000: return a & b;
      4'b0001: return a | b;
      4'b0010: return a + b;
      4'b0110: return a - b;
      4'b0111: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'b1100: return ~(a | b);
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h exp=%h (op=%b a=%h b=%h)", req, got, exp, op_code, opnd_a, opnd_b);
    end
  endtask

  task automatic apply(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b);
    @(posedge clk);
    op_code = c;
    opnd_a  = a;
    opnd_b  = b;
    @(negedge clk);
  endtask

  task automatic run_op(input string req, input logic [3:0] c, input logic [31:0] a,
                        input logic [31:0] b);
    logic [31:0] e;
    e = model(c, a, b);
    apply(c, a, b);
    check(req, result, e);
    check("R7", {31'd0, zero}, {31'd0, e == 32'd0});
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    check("R7 idle", result, 32'd0);
    check("R7 idle", {31'd0, zero}, 32'd1);
  endtask

  task automatic t_logic;
    run_op("R1", 4'b0000, 32'hF0F0_1234, 32'hFF00_FF0F);
    run_op("R1", 4'b0000, 32'hAAAA_5555, 32'h5555_AAAA);
    run_op("R2", 4'b0001, 32'hF0F0_0000, 32'h0000_0F0F);
    run_op("R2", 4'b0001, 32'd0, 32'd0);
    run_op("R6", 4'b1100, 32'h1234_5678, 32'h8000_0001);
    run_op("R6", 4'b1100, 32'hFFFF_FFFF, 32'd0);
    run_op("R6", 4'b1100, 32'd0, 32'd0);
  endtask

  task automatic t_arith;
    run_op("R3", 4'b0010, 32'd7, 32'd35);
    run_op("R3", 4'b0010, 32'hFFFF_FFFF, 32'd1);
    run_op("R3", 4'b0010, 32'h7FFF_FFFF, 32'd1);
    run_op("R4", 4'b0110, 32'd100, 32'd58);
    run_op("R4", 4'b0110, 32'd0, 32'd1);
    run_op("R4", 4'b0110, 32'h8000_0000, 32'd1);
  endtask

  task automatic t_less;
    run_op("R5", 4'b0111, 32'd3, 32'd9);
    run_op("R5", 4'b0111, 32'd9, 32'd3);
    run_op("R5", 4'b0111, 32'hFFFF_FFFF, 32'd0);
    run_op("R5", 4'b0111, 32'h7FFF_FFFF, 32'h8000_0000);
    run_op("R5", 4'b0111, 32'h8000_0000, 32'h7FFF_FFFF);
    run_op("R5", 4'b0111, 32'h8000_0000, 32'd1);
    run_op("R5", 4'b0111, 32'h1234_0000, 32'h1234_0000);
  endtask

  task automatic t_equal;
    apply(4'b0110, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    check("R9 equal", {31'd0, zero}, 32'd1);
    apply(4'b0110, 32'hDEAD_BEEF, 32'hDEAD_BEEE);
    check("R9 differ", {31'd0, zero}, 32'd0);
    apply(4'b0110, 32'h8000_0000, 32'h0000_0000);
    check("R9 differ msb", {31'd0, zero}, 32'd0);
  endtask

  task automatic t_unknown;
    for (int c = 0; c < 16; c++) begin
      if (c == 0 || c == 1 || c == 2 || c == 6 || c == 7 || c == 12) continue;
      apply(4'(c), 32'hC3A5_0F11, 32'h1234_ABCD);
      check("R8", result, 32'd0);
      check("R8 zero", {31'd0, zero}, 32'd1);
    end
  endtask

  task automatic t_sweep;
    logic [31:0] lfsr;
    logic [3:0]  codes [6];
    codes[0] = 4'b0000; codes[1] = 4'b0001; codes[2] = 4'b0010;
    codes[3] = 4'b0110; codes[4] = 4'b0111; codes[5] = 4'b1100;
    lfsr = 32'hACE1_2468;
    for (int n = 0; n < 60; n++) begin
      logic [31:0] a;
      logic [31:0] b;
      a    = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      b    = (n % 5 == 0) ? a : lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      run_op("R1 R2 R3 R4 R5 R6 sweep", codes[n % 6], a, b);
    end
  endtask

  initial begin
    total    = 0;
    bad      = 0;
    finished = 1'b0;
    rst_n    = 1'b0;
    op_code  = 4'b0000;
    opnd_a   = 32'd0;
    opnd_b   = 32'd0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_logic();
    t_arith();
    t_less();
    t_equal();
    t_unknown();
    t_sweep();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: got=timeout exp=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule